// File: doc/BRIEF.md
# Privileged Virtual Segment Decoder

This block sits at the front of a processor's address translation path. Each request carries a 32-bit virtual address, a read/write flag, the current privilege mode and an error-level flag. The decoder picks one of five fixed segments from the top address bits and resolves the access in one of three ways. It can translate directly by removing the segment base. It can hand the address to an external TLB lookup port and pass the TLB's answer through. Or it can reject the access as an address error.

The TLB port is combinational: the lookup strobe, address and write flag are driven in the same cycle as the request, and the TLB answers within that cycle. The response (physical address, write permission, status and address-error flags) is registered and appears one cycle after the request.

Top module: `vseg_decoder`

## Requirements
- R1: For an address below 0x8000_0000 with the error-level flag set, in any mode, the result is status OK (0), physical address equal to the virtual address, write permission 1, and no TLB strobe.
- R2: For an address below 0x8000_0000 with the error-level flag clear, in any mode, the TLB strobe is raised with the request's address and write flag, and the TLB result is passed through.
- R3: Addresses 0x8000_0000..0x9FFF_FFFF in kernel mode give status OK, physical address = address − 0x8000_0000, write permission 1, and no TLB strobe.
- R4: Addresses 0xA000_0000..0xBFFF_FFFF in kernel mode give status OK, physical address = address − 0xA000_0000, write permission 1, and no TLB strobe.
- R5: Addresses 0xC000_0000..0xDFFF_FFFF go to the TLB in kernel or supervisor mode and are rejected in user mode.
- R6: Addresses 0xE000_0000 and above go to the TLB only in kernel mode. Supervisor and user mode are rejected there, and so are both unmapped windows of R3 and R4.
- R7: A rejected access gives status 4 (bad address), physical address 0, write permission 0, and no TLB strobe. It raises the load address-error flag for a read or the store address-error flag for a write, never both.
- R8: The mode input encodes 00 kernel, 01 supervisor, 10 user; 11 behaves exactly as user.
- R9: The response is valid exactly one cycle after a request. With no request, all response outputs are 0. After reset, the response outputs are 0.
- R10: The TLB status codes are passed through unchanged: 0 hit, 1 no match, 2 invalid entry, 3 write to clean page. On a TLB hit, the TLB's physical address and write permission are returned. On any other TLB status, the physical address and write permission are 0 and neither address-error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | Privilege mode (00 kernel, 01 supervisor, 10/11 user) |
| req_erl | input | 1 | Error-level flag |
| tlb_req | output | 1 | TLB lookup strobe |
| tlb_vaddr | output | 32 | Address sent to the TLB |
| tlb_write | output | 1 | Write flag sent to the TLB |
| tlb_pa | input | 32 | TLB physical address |
| tlb_wr_ok | input | 1 | TLB write permission |
| tlb_status | input | 2 | TLB result code |
| rsp_valid | output | 1 | Response valid |
| rsp_pa | output | 32 | Physical address |
| rsp_wr_ok | output | 1 | Write permission |
| rsp_status | output | 3 | Final status (0..3 TLB codes, 4 bad address) |
| rsp_adel | output | 1 | Load address error |
| rsp_ades | output | 1 | Store address error |

## Verification
A wrong segment choice or a wrong privilege gate shows up in two places. The TLB strobe is wrong in the same cycle as the request, and the status or address-error flags are wrong one cycle later. A bad base subtraction only shows in the physical address of a direct-window access, so random addresses across all eight top-bit patterns are crossed with every mode and both error-level values. The bench's TLB model returns an address derived from the lookup address. Any mix-up between the TLB result and the direct result is therefore visible on the next cycle.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  localparam int VA_W = 32;

  typedef enum logic [2:0] {
    SEG_USER    = 3'd0,
    SEG_KWIN_C  = 3'd1,
    SEG_KWIN_U  = 3'd2,
    SEG_SUPV    = 3'd3,
    SEG_KMAP    = 3'd4
  } seg_e;

  typedef enum logic [2:0] {
    ST_OK        = 3'd0,
    ST_MISS      = 3'd1,
    ST_INVALID   = 3'd2,
    ST_CLEAN     = 3'd3,
    ST_BAD_ADDR  = 3'd4
  } status_e;

  localparam logic [VA_W-1:0] KWIN_C_BASE = 32'h8000_0000;
  localparam logic [VA_W-1:0] KWIN_U_BASE = 32'hA000_0000;

  function automatic seg_e seg_of(input logic [2:0] top3);
    case (top3)
      3'd4:    return SEG_KWIN_C;
      3'd5:    return SEG_KWIN_U;
      3'd6:    return SEG_SUPV;
      3'd7:    return SEG_KMAP;
      default: return SEG_USER;
    endcase
  endfunction

  function automatic logic mode_kernel(input logic [1:0] m);
    return m == 2'b00;
  endfunction

  function automatic logic mode_supv(input logic [1:0] m);
    return m == 2'b01;
  endfunction

  function automatic logic [VA_W-1:0] strip_base(input logic [VA_W-1:0] a,
                                                 input logic [VA_W-1:0] base);
    return a - base;
  endfunction
endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
  import vseg_pkg::*;
#(
  parameter int ADDR_W = VA_W
) (
  input  logic [ADDR_W-1:0] vaddr,
  output seg_e              seg,
  output logic              mapped,
  output logic [ADDR_W-1:0] direct_pa
);
  localparam int TOP_LSB = ADDR_W - 3;

  always_comb begin
    seg = seg_of(vaddr[ADDR_W-1:TOP_LSB]);
    mapped = (seg == SEG_SUPV) || (seg == SEG_KMAP);
    case (seg)
      SEG_KWIN_C: direct_pa = strip_base(vaddr, KWIN_C_BASE);
      SEG_KWIN_U: direct_pa = strip_base(vaddr, KWIN_U_BASE);
      default:    direct_pa = vaddr;
    endcase
  end
endmodule

// File: rtl/vseg_gate.sv
module vseg_gate
  import vseg_pkg::*;
(
  input  seg_e       seg,
  input  logic       mapped,
  input  logic [1:0] mode,
  input  logic       erl,
  output logic       allowed,
  output logic       use_tlb
);
  logic kern, supv;

  always_comb begin
    kern = mode_kernel(mode);
    supv = mode_supv(mode);
    case (seg)
      SEG_USER:   allowed = 1'b1;
      SEG_SUPV:   allowed = kern || supv;
      default:    allowed = kern;
    endcase
    use_tlb = allowed && (mapped || (seg == SEG_USER && !erl));
  end
endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
  import vseg_pkg::*;
#(
  parameter int ADDR_W = VA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic [1:0]        req_mode,
  input  logic              req_erl,
  output logic              tlb_req,
  output logic [ADDR_W-1:0] tlb_vaddr,
  output logic              tlb_write,
  input  logic [ADDR_W-1:0] tlb_pa,
  input  logic              tlb_wr_ok,
  input  logic [1:0]        tlb_status,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic              rsp_wr_ok,
  output logic [2:0]        rsp_status,
  output logic              rsp_adel,
  output logic              rsp_ades
);
  seg_e              seg;
  logic              mapped;
  logic [ADDR_W-1:0] direct_pa;
  logic              allowed;
  logic              use_tlb;

  // named internal events for the checks
  logic              ev_reject;
  logic              ev_direct;
  logic              ev_tlb_hit;

  logic [ADDR_W-1:0] nxt_pa;
  logic              nxt_wr;
  logic [2:0]        nxt_st;

  vseg_classify #(.ADDR_W(ADDR_W)) u_classify (
    .vaddr     (req_vaddr),
    .seg       (seg),
    .mapped    (mapped),
    .direct_pa (direct_pa)
  );

  vseg_gate u_gate (
    .seg     (seg),
    .mapped  (mapped),
    .mode    (req_mode),
    .erl     (req_erl),
    .allowed (allowed),
    .use_tlb (use_tlb)
  );

  assign tlb_req   = req_valid && use_tlb;
  assign tlb_vaddr = req_vaddr;
  assign tlb_write = req_write;

  assign ev_reject  = req_valid && !allowed;
  assign ev_direct  = req_valid && allowed && !use_tlb;
  assign ev_tlb_hit = tlb_req && (tlb_status == 2'd0);

  always_comb begin
    nxt_pa = '0;
    nxt_wr = 1'b0;
    nxt_st = ST_OK;
    if (ev_reject) begin
      nxt_st = ST_BAD_ADDR;
    end else if (ev_direct) begin
      nxt_pa = direct_pa;
      nxt_wr = 1'b1;
    end else if (tlb_req) begin
      nxt_st = {1'b0, tlb_status};
      if (ev_tlb_hit) begin
        nxt_pa = tlb_pa;
        nxt_wr = tlb_wr_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      rsp_valid  <= 1'b0;
      rsp_pa     <= '0;
      rsp_wr_ok  <= 1'b0;
      rsp_status <= '0;
      rsp_adel   <= 1'b0;
      rsp_ades   <= 1'b0;
    end else begin
      rsp_valid  <= 1'b1;
      rsp_pa     <= nxt_pa;
      rsp_wr_ok  <= nxt_wr;
      rsp_status <= nxt_st;
      rsp_adel   <= ev_reject && !req_write;
      rsp_ades   <= ev_reject && req_write;
    end
  end

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_status == 3'd0 && rsp_pa == '0));
  // R7
  adel_ades_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_adel, rsp_ades}));
  // R7
  bad_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_status == 3'd4) == (rsp_adel || rsp_ades));
  // R7
  reject_no_tlb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |-> !tlb_req);
  // R3
  direct_window_no_tlb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr[ADDR_W-1 -: 2] == 2'b10) |-> !tlb_req);
  // R10
  wr_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wr_ok |-> (rsp_valid && rsp_status == 3'd0));
  // R6
  kmap_kernel_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req && tlb_vaddr[ADDR_W-1 -: 3] == 3'b111) |-> (req_mode == 2'b00));
endmodule

// File: tb/test_vseg_decoder.sv
module test_vseg_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_mode = '0;
  logic        req_erl = 1'b0;
  logic        tlb_req;
  logic [31:0] tlb_vaddr;
  logic        tlb_write;
  logic [31:0] tlb_pa;
  logic        tlb_wr_ok = 1'b0;
  logic [1:0]  tlb_status = '0;
  logic        rsp_valid;
  logic [31:0] rsp_pa;
  logic        rsp_wr_ok;
  logic [2:0]  rsp_status;
  logic        rsp_adel;
  logic        rsp_ades;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // bench TLB model: address derived from the lookup address
  assign tlb_pa = tlb_vaddr ^ 32'h0F0F_00F0;

  vseg_decoder i_vseg_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_mode(req_mode), .req_erl(req_erl),
    .tlb_req(tlb_req), .tlb_vaddr(tlb_vaddr), .tlb_write(tlb_write),
    .tlb_pa(tlb_pa), .tlb_wr_ok(tlb_wr_ok), .tlb_status(tlb_status),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_wr_ok(rsp_wr_ok),
    .rsp_status(rsp_status), .rsp_adel(rsp_adel), .rsp_ades(rsp_ades)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected decision: 0 reject, 1 direct, 2 tlb
  function automatic int decide(input logic [31:0] a, input logic [1:0] m,
                                input logic erl);
    bit k = (m == 2'b00);
    bit s = (m == 2'b01);
    if (a < 32'h8000_0000) return erl ? 1 : 2;
    if (a < 32'hC000_0000) return k ? 1 : 0;
    if (a < 32'hE000_0000) return (k || s) ? 2 : 0;
    return k ? 2 : 0;
  endfunction

  function automatic logic [31:0] direct_addr(input logic [31:0] a);
    if (a >= 32'hA000_0000 && a < 32'hC000_0000) return a - 32'hA000_0000;
    if (a >= 32'h8000_0000 && a < 32'hA000_0000) return a - 32'h8000_0000;
    return a;
  endfunction

  task automatic run(input logic [31:0] a, input logic w, input logic [1:0] m,
                     input logic erl, input logic twr, input logic [1:0] tst,
                     input string tag);
    int d = decide(a, m, erl);
    logic [31:0] e_pa;
    logic        e_wr;
    logic [2:0]  e_st;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = a; req_write = w; req_mode = m; req_erl = erl;
    tlb_wr_ok = twr; tlb_status = tst;
    #1;
    chk(tlb_req == (d == 2), {tag, " tlb_req"}, tlb_req, d == 2);
    if (d == 2)
      chk(tlb_vaddr == a && tlb_write == w, {tag, " tlb addr/write"},
          {tlb_vaddr, 31'd0, tlb_write}, {a, 31'd0, w});
    case (d)
      0: begin e_pa = '0; e_wr = 1'b0; e_st = 3'd4; end
      1: begin e_pa = direct_addr(a); e_wr = 1'b1; e_st = 3'd0; end
      default: begin
        e_st = {1'b0, tst};
        e_pa = (tst == 2'd0) ? (a ^ 32'h0F0F_00F0) : 32'd0;
        e_wr = (tst == 2'd0) ? twr : 1'b0;
      end
    endcase
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, {tag, " R9 valid"}, rsp_valid, 1);
    chk(rsp_pa === e_pa, {tag, " pa"}, rsp_pa, e_pa);
    chk(rsp_wr_ok === e_wr, {tag, " wr_ok"}, rsp_wr_ok, e_wr);
    chk(rsp_status === e_st, {tag, " status"}, rsp_status, e_st);
    chk(rsp_adel === (d == 0 && !w) && rsp_ades === (d == 0 && w),
        {tag, " R7 adel/ades"}, {rsp_adel, rsp_ades}, {d == 0 && !w, d == 0 && w});
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(rsp_valid === 1'b0 && rsp_status === 3'd0 && rsp_pa === 32'd0,
        "R9 reset", {rsp_valid, rsp_status}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9 idle", rsp_valid, 0);

    // directed corners
    run(32'h7FFF_FFFC, 1, 2'b10, 1, 0, 0, "R1 erl user");
    run(32'h0000_1000, 0, 2'b00, 0, 1, 0, "R2 tlb hit");
    run(32'h1234_5678, 1, 2'b10, 0, 0, 2'd1, "R10 miss");
    run(32'h1234_5678, 1, 2'b01, 0, 0, 2'd3, "R10 clean");
    run(32'h8000_0000, 0, 2'b00, 0, 0, 0, "R3 low edge");
    run(32'h9FFF_FFFF, 1, 2'b00, 1, 0, 0, "R3 high edge");
    run(32'hA000_0000, 0, 2'b00, 0, 0, 0, "R4 low edge");
    run(32'hBFFF_FFFF, 1, 2'b00, 0, 0, 0, "R4 high edge");
    run(32'h9000_0000, 0, 2'b01, 0, 0, 0, "R6 supv kwin reject");
    run(32'hB000_0000, 1, 2'b10, 0, 0, 0, "R7 user store reject");
    run(32'hC000_0000, 0, 2'b01, 0, 1, 0, "R5 supv ok");
    run(32'hDFFF_FFFF, 0, 2'b10, 0, 1, 0, "R5 user reject");
    run(32'hD000_0000, 1, 2'b11, 0, 1, 0, "R8 mode11 reject");
    run(32'hE000_0000, 0, 2'b00, 0, 1, 2'd2, "R6 kernel invalid");
    run(32'hFFFF_FFFF, 1, 2'b01, 0, 1, 0, "R6 supv reject");
    run(32'h0000_0040, 0, 2'b11, 0, 1, 0, "R8 mode11 user seg");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      run($urandom, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
          2'($urandom), "R2 R5 R6 R8 random");
    end
    @(negedge clk);
    chk(rsp_valid === 1'b0 && rsp_pa === 32'd0, "R9 idle after traffic", rsp_valid, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule